// File: doc/BRIEF.md
# Zero-Delay Clock Buffer Output Controller

This block is the digital control around a clock fan-out buffer that drives two banks of four outputs. A reference clock and the output of an external PLL both arrive as signals. A free-running sampling clock samples them through synchronizers. A two-bit select input picks one of four operating modes. Each mode sets which banks are driven, whether the outputs come from the PLL clock or straight from the reference, and whether the PLL is asked to shut down. A two-bit configuration code sets the divide ratio of each bank, and in one configuration it also inverts the bypass path.

A watchdog on reference activity counts sampling cycles since the last reference rising edge. When the count runs out, the block enters power-down: both banks are tri-stated and PLL shutdown is requested. The first new reference edge ends power-down. After that, and after any PLL restart, the PLL-sourced outputs wait for a lock interval before they are enabled. The bank dividers are held cleared while the PLL is off, so both banks start from the same phase when it comes back. Each bank is modelled as four identical data bits plus one active-high output enable.

Top module: `zdb_out_ctrl`

## Requirements
- R1: Select code 00 (sel_i[1] is the upper bit) disables both banks, asserts pll_off_o and keeps bypass_o low.
- R2: Select code 01 enables bank A from the PLL path, keeps bank B disabled and leaves pll_off_o low. Bank B is never enabled while bank A is disabled.
- R3: Select code 10 enables both banks from the reference without division, raises bypass_o and asserts pll_off_o. Bank data then equals the reference level sampled three sampling-clock edges earlier.
- R4: Select code 11 enables both banks from the PLL path with pll_off_o low.
- R5: With configuration code 1 in select code 10, the bank data is the inverse of the delayed reference. Other configuration codes pass it uninverted.
- R6: In PLL modes, configuration 0 and configuration 3 run both banks at the PLL rate. Configuration 1 halves bank B only. Configuration 2 halves both banks.
- R7: The select synchronizer comes out of reset holding code 11. pll_off_o therefore stays low for the first two edges after reset, whatever the select pins carry.
- R8: After LOSS_CYC sampling cycles with no reference rising edge, pwrdn_o rises. From the next cycle on, both enables stay low and pll_off_o stays high. The first detected reference edge clears pwrdn_o.
- R9: PLL-sourced enables stay low for LOCK_CYC sampling cycles after power-down ends or after the PLL shutdown request drops. The bypass path is not delayed.
- R10: Dividers restart phase-aligned: whenever both banks are enabled, bank B never rises in a cycle in which bank A does not.
- R11: All bits of a bank are always equal, and a disabled bank drives zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| samp_clk | input | 1 | Free-running sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Reference clock, sampled as data |
| pll_clk_i | input | 1 | External PLL output clock, sampled as data |
| sel_i | input | 2 | Mode select, bit 1 upper |
| cfg_i | input | 2 | Divide/inversion configuration |
| a_dat_o | output | 4 | Bank A output data |
| a_oe_o | output | 1 | Bank A output enable |
| b_dat_o | output | 4 | Bank B output data |
| b_oe_o | output | 1 | Bank B output enable |
| bypass_o | output | 1 | Outputs sourced from the reference |
| pll_off_o | output | 1 | PLL shutdown request |
| pwrdn_o | output | 1 | Reference-loss power-down active |

## Verification
The hardest state to reach is the end of power-down. The reference must be silent for a full loss interval, but only after it has been toggling long enough to prove the earlier modes. When it resumes, the enables must still be held low for the lock interval. The stimulus runs the reference from a generator with a run flag. It clears the flag, samples once before and once after the loss limit, then sets the flag again and samples inside the lock window and after it. The same lock gating is reached through a select change from bypass back to PLL mode. The three-edge reference latency is checked against a history of the reference sampled at each clock edge.

// File: rtl/zdb_pkg.sv
package zdb_pkg;

    typedef enum logic [1:0] {
        CFG_SAME     = 2'd0,
        CFG_HALF_B   = 2'd1,
        CFG_HALF_ALL = 2'd2,
        CFG_SPARE    = 2'd3
    } cfg_e;

    typedef struct packed {
        logic a_on;
        logic b_on;
        logic bypass;
        logic pll_stop;
    } sel_dec_t;

    function automatic sel_dec_t decode_sel(input logic [1:0] s);
        sel_dec_t r;
        unique case (s)
            2'b00:   r = '{a_on: 1'b0, b_on: 1'b0, bypass: 1'b0, pll_stop: 1'b1};
            2'b01:   r = '{a_on: 1'b1, b_on: 1'b0, bypass: 1'b0, pll_stop: 1'b0};
            2'b10:   r = '{a_on: 1'b1, b_on: 1'b1, bypass: 1'b1, pll_stop: 1'b1};
            default: r = '{a_on: 1'b1, b_on: 1'b1, bypass: 1'b0, pll_stop: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/zdb_sync_edge.sv
module zdb_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic lvl_o,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = async_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl_o  = st_q.s2;
    assign rise_o = st_q.s2 & ~st_q.prev;
endmodule

// File: rtl/zdb_ref_watch.sv
module zdb_ref_watch #(
    parameter int LOSS_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    output logic lost_o
);
    localparam int CW = $clog2(LOSS_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(LOSS_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lost;
    } watch_st_t;

    watch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise_i) begin
            st_d.cnt  = '0;
            st_d.lost = 1'b0;
        end else if (st_q.cnt == LAST) begin
            st_d.lost = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lost_o = st_q.lost;
endmodule

// File: rtl/zdb_bank_div.sv
module zdb_bank_div #(
    parameter int N_OUT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             src_lvl_i,
    input  logic             src_rise_i,
    input  logic             ref_lvl_i,
    input  logic             half_i,
    input  logic             bypass_i,
    input  logic             invert_i,
    input  logic             en_i,
    output logic [N_OUT-1:0] dat_o,
    output logic             oe_o
);
    typedef struct packed {
        logic tog;
        logic dat;
        logic oe;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.tog = clr_i ? 1'b0 : (st_q.tog ^ src_rise_i);
        if (!en_i)         st_d.dat = 1'b0;
        else if (bypass_i) st_d.dat = ref_lvl_i ^ invert_i;
        else if (half_i)   st_d.dat = st_d.tog;
        else               st_d.dat = src_lvl_i;
        st_d.oe  = en_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_fan
        assign dat_o[i] = st_q.dat;
    end

    assign oe_o = st_q.oe;
endmodule

// File: rtl/zdb_out_ctrl.sv
module zdb_out_ctrl #(
    parameter int N_OUT    = 4,
    parameter int LOSS_CYC = 32,
    parameter int LOCK_CYC = 20
) (
    input  logic             samp_clk,
    input  logic             rst_n,
    input  logic             ref_clk_i,
    input  logic             pll_clk_i,
    input  logic [1:0]       sel_i,
    input  logic [1:0]       cfg_i,
    output logic [N_OUT-1:0] a_dat_o,
    output logic             a_oe_o,
    output logic [N_OUT-1:0] b_dat_o,
    output logic             b_oe_o,
    output logic             bypass_o,
    output logic             pll_off_o,
    output logic             pwrdn_o
);
    import zdb_pkg::*;

    localparam int LW = $clog2(LOCK_CYC + 1);
    localparam logic [LW-1:0] LOCK_LAST = LW'(LOCK_CYC - 1);

    typedef struct packed {
        logic [1:0]    sel_s1;
        logic [1:0]    sel_s2;
        logic [LW-1:0] lock_cnt;
        logic          lock_rdy;
        logic          byp;
        logic          off;
    } top_st_t;

    localparam top_st_t TOP_RST = '{sel_s1: 2'b11, sel_s2: 2'b11, lock_cnt: '0,
                                    lock_rdy: 1'b0, byp: 1'b0, off: 1'b0};

    top_st_t  st_d, st_q;
    sel_dec_t dec;
    cfg_e     cfg;
    logic     ref_lvl, ref_rise, pll_lvl, pll_rise, lost;
    logic     stop_all, en_a, en_b, half_a, half_b, inv;

    zdb_sync_edge u_ref_sync (
        .clk(samp_clk), .rst_n(rst_n), .async_i(ref_clk_i),
        .lvl_o(ref_lvl), .rise_o(ref_rise)
    );

    zdb_sync_edge u_pll_sync (
        .clk(samp_clk), .rst_n(rst_n), .async_i(pll_clk_i),
        .lvl_o(pll_lvl), .rise_o(pll_rise)
    );

    zdb_ref_watch #(.LOSS_CYC(LOSS_CYC)) u_watch (
        .clk(samp_clk), .rst_n(rst_n), .rise_i(ref_rise), .lost_o(lost)
    );

    always_comb begin
        cfg      = cfg_e'(cfg_i);
        dec      = decode_sel(st_q.sel_s2);
        stop_all = dec.pll_stop | lost;
        half_a   = (cfg == CFG_HALF_ALL);
        half_b   = (cfg == CFG_HALF_ALL) || (cfg == CFG_HALF_B);
        inv      = (cfg == CFG_HALF_B);
        en_a     = dec.a_on & ~lost & (dec.bypass | st_q.lock_rdy);
        en_b     = dec.b_on & ~lost & (dec.bypass | st_q.lock_rdy);

        st_d        = st_q;
        st_d.sel_s1 = sel_i;
        st_d.sel_s2 = st_q.sel_s1;
        st_d.byp    = dec.bypass;
        st_d.off    = stop_all;
        if (stop_all) begin
            st_d.lock_cnt = '0;
            st_d.lock_rdy = 1'b0;
        end else if (!st_q.lock_rdy) begin
            if (st_q.lock_cnt == LOCK_LAST) st_d.lock_rdy = 1'b1;
            else                            st_d.lock_cnt = st_q.lock_cnt + 1'b1;
        end
    end

    always_ff @(posedge samp_clk or negedge rst_n) begin
        if (!rst_n) st_q <= TOP_RST;
        else        st_q <= st_d;
    end

    zdb_bank_div #(.N_OUT(N_OUT)) u_bank_a (
        .clk(samp_clk), .rst_n(rst_n), .clr_i(stop_all),
        .src_lvl_i(pll_lvl), .src_rise_i(pll_rise), .ref_lvl_i(ref_lvl),
        .half_i(half_a), .bypass_i(dec.bypass), .invert_i(inv), .en_i(en_a),
        .dat_o(a_dat_o), .oe_o(a_oe_o)
    );

    zdb_bank_div #(.N_OUT(N_OUT)) u_bank_b (
        .clk(samp_clk), .rst_n(rst_n), .clr_i(stop_all),
        .src_lvl_i(pll_lvl), .src_rise_i(pll_rise), .ref_lvl_i(ref_lvl),
        .half_i(half_b), .bypass_i(dec.bypass), .invert_i(inv), .en_i(en_b),
        .dat_o(b_dat_o), .oe_o(b_oe_o)
    );

    assign bypass_o  = st_q.byp;
    assign pll_off_o = st_q.off;
    assign pwrdn_o   = lost;
endmodule

// File: rtl/zdb_out_ctrl_chk.sv
module zdb_out_ctrl_chk #(
    parameter int N_OUT = 4
) (
    input logic             samp_clk,
    input logic             rst_n,
    input logic [N_OUT-1:0] a_dat_o,
    input logic             a_oe_o,
    input logic [N_OUT-1:0] b_dat_o,
    input logic             b_oe_o,
    input logic             bypass_o,
    input logic             pll_off_o,
    input logic             pwrdn_o
);
    AST_PWRDN_TRISTATE: assert property (@(posedge samp_clk) disable iff (!rst_n)
        ($past(pwrdn_o) && pwrdn_o) |-> (!a_oe_o && !b_oe_o)); // R8
    AST_PWRDN_PLLOFF: assert property (@(posedge samp_clk) disable iff (!rst_n)
        ($past(pwrdn_o) && pwrdn_o) |-> pll_off_o); // R8
    AST_BYPASS_PLLOFF: assert property (@(posedge samp_clk) disable iff (!rst_n)
        bypass_o |-> pll_off_o); // R3
    AST_B_NEEDS_A: assert property (@(posedge samp_clk) disable iff (!rst_n)
        b_oe_o |-> a_oe_o); // R2
    AST_BANK_UNIFORM: assert property (@(posedge samp_clk) disable iff (!rst_n)
        ((a_dat_o == '0) || (a_dat_o == {N_OUT{1'b1}})) &&
        ((b_dat_o == '0) || (b_dat_o == {N_OUT{1'b1}}))); // R11
endmodule

bind zdb_out_ctrl zdb_out_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
    .samp_clk(samp_clk), .rst_n(rst_n),
    .a_dat_o(a_dat_o), .a_oe_o(a_oe_o), .b_dat_o(b_dat_o), .b_oe_o(b_oe_o),
    .bypass_o(bypass_o), .pll_off_o(pll_off_o), .pwrdn_o(pwrdn_o)
);

// File: tb/zdb_out_ctrl_tb_top.sv
`timescale 1ns/1ps
module zdb_out_ctrl_tb_top;
    localparam int NO   = 4;
    localparam int LOSS = 32;
    localparam int LOCK = 20;
    localparam int WIN  = 240;

    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] cfg;
        logic       oa;
        logic       ob;
        logic       byp;
        logic       off;
        int         na;
        int         nb;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{2'b11, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 40, 40},
        '{2'b11, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 40, 20},
        '{2'b11, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 20, 20},
        '{2'b01, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 40, 0},
        '{2'b01, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 40, 0},
        '{2'b00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 0, 0},
        '{2'b10, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 30, 30},
        '{2'b10, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 30, 30},
        '{2'b10, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 30, 30},
        '{2'b11, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 40, 40}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_clk = 1'b0;
    logic          pll_clk = 1'b0;
    logic          ref_run = 1'b1;
    logic [1:0]    sel = 2'b00;
    logic [1:0]    cfg = 2'd0;
    logic [NO-1:0] a_dat, b_dat;
    logic          a_oe, b_oe, byp, off, pwrdn;
    logic [2:0]    hist = '0;
    int            total = 0;
    int            bad = 0;
    bit            done = 0;

    always #4 clk = ~clk;

    zdb_out_ctrl #(.N_OUT(NO), .LOSS_CYC(LOSS), .LOCK_CYC(LOCK)) dut_i (
        .samp_clk(clk), .rst_n(rst_n), .ref_clk_i(ref_clk), .pll_clk_i(pll_clk),
        .sel_i(sel), .cfg_i(cfg), .a_dat_o(a_dat), .a_oe_o(a_oe),
        .b_dat_o(b_dat), .b_oe_o(b_oe), .bypass_o(byp), .pll_off_o(off),
        .pwrdn_o(pwrdn)
    );

    always @(posedge clk) hist <= {hist[1:0], ref_clk};

    initial forever begin
        repeat (4) @(negedge clk);
        ref_clk = ref_run ? ~ref_clk : 1'b0;
    end

    initial forever begin
        repeat (3) @(negedge clk);
        pll_clk = ~pll_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        chk(a_oe == 1'b0 && b_oe == 1'b0, "R1 reset enables", {a_oe, b_oe}, 0);
        chk(pwrdn == 1'b0, "R8 reset pwrdn", pwrdn, 0);
        rst_n = 1'b1;
        wait_n(1);
        chk(off == 1'b0, "R7 select default edge1", off, 0);
        wait_n(1);
        chk(off == 1'b0, "R7 select default edge2", off, 0);
        wait_n(2);
        chk(off == 1'b1, "R1 code00 pll_off", off, 1);

        for (int i = 0; i < 10; i++) begin
            int  na, nb, mis, inv_err;
            logic pa, pb, inv;
            sel = VEC[i].sel;
            cfg = VEC[i].cfg;
            wait_n(64);
            chk(a_oe == VEC[i].oa, "R1 R2 R4 bank A enable", a_oe, VEC[i].oa);
            chk(b_oe == VEC[i].ob, "R1 R2 R4 bank B enable", b_oe, VEC[i].ob);
            chk(byp == VEC[i].byp, "R3 bypass flag", byp, VEC[i].byp);
            chk(off == VEC[i].off, "R1 R3 R4 pll_off", off, VEC[i].off);
            na = 0; nb = 0; mis = 0; inv_err = 0;
            pa = a_dat[0]; pb = b_dat[0];
            inv = (VEC[i].cfg == 2'd1);
            for (int c = 0; c < WIN; c++) begin
                @(negedge clk);
                if (a_dat[0] && !pa) na++;
                if (b_dat[0] && !pb) nb++;
                if (b_dat[0] && !pb && !(a_dat[0] && !pa)) mis++;
                if (VEC[i].byp && (a_dat[0] != (hist[2] ^ inv))) inv_err++;
                pa = a_dat[0]; pb = b_dat[0];
            end
            chk(na == VEC[i].na, "R6 bank A edge count", na, VEC[i].na);
            chk(nb == VEC[i].nb, "R6 R11 bank B edge count", nb, VEC[i].nb);
            if (VEC[i].oa && VEC[i].ob)
                chk(mis == 0, "R10 bank B edge without bank A edge", mis, 0);
            if (VEC[i].byp)
                chk(inv_err == 0, "R3 R5 bypass latency and inversion", inv_err, 0);
        end

        sel = 2'b10;
        wait_n(12);
        chk(a_oe == 1'b1, "R9 bypass not lock gated", a_oe, 1);
        sel = 2'b11;
        wait_n(12);
        chk(a_oe == 1'b0, "R9 lock wait after PLL restart", a_oe, 0);
        wait_n(30);
        chk(a_oe == 1'b1, "R9 enabled after lock wait", a_oe, 1);

        ref_run = 1'b0;
        wait_n(16);
        chk(pwrdn == 1'b0, "R8 no loss before limit", pwrdn, 0);
        wait_n(40);
        chk(pwrdn == 1'b1, "R8 loss declared", pwrdn, 1);
        chk(a_oe == 1'b0 && b_oe == 1'b0, "R8 tri-stated in power-down", {a_oe, b_oe}, 0);
        chk(a_dat == '0 && b_dat == '0, "R11 disabled bank drives zero", {a_dat, b_dat}, 0);
        chk(off == 1'b1, "R8 pll_off in power-down", off, 1);
        ref_run = 1'b1;
        wait_n(14);
        chk(pwrdn == 1'b0, "R8 loss cleared by edge", pwrdn, 0);
        chk(a_oe == 1'b0, "R9 lock wait after power-down", a_oe, 0);
        wait_n(40);
        chk(a_oe == 1'b1 && b_oe == 1'b1, "R9 R4 enabled after recovery", {a_oe, b_oe}, 3);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule